// File: doc/BRIEF.md
# Write-Streaming Mode Detector

This block watches the store and load traffic of a data cache and decides whether write misses still need a line fill. It keeps a byte-valid mask for the line that stores are currently filling. When that mask becomes all ones, the line counts as fully overwritten. A run counter tracks how many such lines have completed one after another at ascending line addresses. Once the run reaches a threshold, the block raises a streaming flag. While the flag is high, every store miss is told to skip the read-for-ownership fill and send its data straight to the next level without allocating.

Any evidence that the program reads the data it writes drops the mode at once. This is a load to the line being filled, or a store stream that leaves a line half written and moves on. A jump to a line that does not follow the previous one starts the run again at one. The decision for a store miss is given in the same cycle as the miss. It is based on the mode in force before that store is applied.

Top module: `wstream_detect`

## Requirements
- R1: After reset, the streaming flag is low, no line is being tracked and the run count is zero.
- R2: For every store with `st_miss` high, `dec_valid` is high in the same cycle, and `dec_nofill` equals the streaming flag held before that store is applied. `dec_valid` is low for store hits and for idle cycles.
- R3: Stores to the tracked line accumulate into its byte mask, where bit i stands for byte i of the line. A line completes when the mask is all ones, whether that comes from one store or from several.
- R4: A completed line whose address is exactly one above the previous completed line extends the run. Any other completed line restarts the run at one, and this clears the streaming flag when the threshold is above one.
- R5: The streaming flag rises at the clock edge where the run count reaches THRESH. The count saturates at THRESH, and further consecutive lines keep the flag high.
- R6: A load to the line currently being filled clears the run count and the flag and drops the tracked line. Loads to other lines, including lines already completed, have no effect.
- R7: A store to a new line while the tracked line is only partly written abandons the old line. It clears the run count and the flag, and the new line starts a run of one if it completes.
- R8: When a load and a store arrive in the same cycle, the load is applied first and the store after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | A store event is present |
| st_miss | input | 1 | The store missed in the cache |
| st_line | input | ADDR_W | Line address of the store |
| st_mask | input | LINE_BYTES | Bytes of the line written by the store |
| ld_valid | input | 1 | A load event is present |
| ld_line | input | ADDR_W | Line address of the load |
| stream_mode | output | 1 | Streaming mode is active |
| dec_valid | output | 1 | A fill decision is given for a store miss this cycle |
| dec_nofill | output | 1 | The store miss skips the fill and writes through |

## Verification
The bench builds the block with THRESH of 4, 64-byte lines and 16-bit line addresses. With a threshold of four, a run can be entered, pushed into saturation and broken in every way within a short table. The ways it can be broken are a load hit, an abandoned partial line, an address gap, and a load and a store to the same line in one cycle. The 64-byte line lets half-line masks build a completed line from two stores in either order, so the mask accumulation is exercised alongside the run rules.

// File: rtl/wstream_pkg.sv
package wstream_pkg;
  // Default geometry shared by the detector and its checker.
  localparam int unsigned WS_LINE_BYTES_DEF = 64;
  localparam int unsigned WS_ADDR_W_DEF     = 26;
  localparam int unsigned WS_THRESH_DEF     = 4;

  // Run events raised by the line tracker in one cycle.
  typedef struct packed {
    logic done;  // tracked line reached an all-ones mask
    logic kill;  // evidence of a read or an abandoned partial line
  } ws_evt_t;
endpackage

// File: rtl/wstream_line_track.sv
module wstream_line_track
  import wstream_pkg::*;
#(
  parameter int unsigned LINE_BYTES = WS_LINE_BYTES_DEF,
  parameter int unsigned ADDR_W     = WS_ADDR_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [ADDR_W-1:0]     st_line,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic                  ld_valid,
  input  logic [ADDR_W-1:0]     ld_line,
  output logic                  trk_valid,
  output logic [ADDR_W-1:0]     trk_line,
  output ws_evt_t               evt,
  output logic [ADDR_W-1:0]     done_line
);

  logic                  valid_q, valid_d;
  logic [ADDR_W-1:0]     line_q, line_d;
  logic [LINE_BYTES-1:0] mask_q, mask_d;

  logic                  ld_hit;
  logic                  live_after_ld;
  logic                  same_line;
  logic                  abandon;
  logic [LINE_BYTES-1:0] merged;
  logic                  full;
  logic                  upd_en;

  always_comb begin
    // Load side is applied before the store of the same cycle.
    ld_hit        = ld_valid && valid_q && (ld_line == line_q);
    live_after_ld = valid_q && !ld_hit;
    same_line     = st_valid && live_after_ld && (st_line == line_q);
    abandon       = st_valid && live_after_ld && !same_line;
    merged        = (same_line ? mask_q : '0) | st_mask;
    full          = st_valid && (&merged);
    upd_en        = st_valid || ld_hit;

    valid_d = valid_q;
    line_d  = line_q;
    mask_d  = mask_q;
    if (st_valid) begin
      valid_d = !full;
      line_d  = st_line;
      mask_d  = full ? '0 : merged;
    end else if (ld_hit) begin
      valid_d = 1'b0;
      mask_d  = '0;
    end

    evt.done  = full;
    evt.kill  = ld_hit || abandon;
    done_line = st_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      mask_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      line_q  <= line_d;
      mask_q  <= mask_d;
    end
  end

  assign trk_valid = valid_q;
  assign trk_line  = line_q;

endmodule

// File: rtl/wstream_run_count.sv
module wstream_run_count
  import wstream_pkg::*;
#(
  parameter int unsigned ADDR_W = WS_ADDR_W_DEF,
  parameter int unsigned THRESH = WS_THRESH_DEF
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  ws_evt_t                             evt,
  input  logic [ADDR_W-1:0]                   done_line,
  output logic [$clog2(THRESH+1)-1:0]         run_cnt,
  output logic                                mode
);

  localparam int unsigned CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_base;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              mode_q, mode_d;
  logic              seq_ok;
  logic              upd_en;

  always_comb begin
    cnt_base = evt.kill ? '0 : cnt_q;
    seq_ok   = (cnt_base != '0) && (done_line == last_q + 1'b1);
    cnt_d    = cnt_base;
    last_d   = last_q;
    if (evt.done) begin
      last_d = done_line;
      if (!seq_ok)                cnt_d = CNT_ONE;
      else if (cnt_base != CNT_MAX) cnt_d = cnt_base + CNT_ONE;
    end
    mode_d = (cnt_d >= CNT_MAX);
    upd_en = evt.done || evt.kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
      mode_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      mode_q <= mode_d;
    end
  end

  assign run_cnt = cnt_q;
  assign mode    = mode_q;

endmodule

// File: rtl/wstream_detect.sv
module wstream_detect
  import wstream_pkg::*;
#(
  parameter int unsigned LINE_BYTES = WS_LINE_BYTES_DEF,
  parameter int unsigned ADDR_W     = WS_ADDR_W_DEF,
  parameter int unsigned THRESH     = WS_THRESH_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic                  st_miss,
  input  logic [ADDR_W-1:0]     st_line,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic                  ld_valid,
  input  logic [ADDR_W-1:0]     ld_line,
  output logic                  stream_mode,
  output logic                  dec_valid,
  output logic                  dec_nofill
);

  localparam int unsigned CNT_W = $clog2(THRESH + 1);

  // Reset asserts at once and releases on the second clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              trk_valid;
  logic [ADDR_W-1:0] trk_line;
  ws_evt_t           evt;
  logic [ADDR_W-1:0] done_line;
  logic [CNT_W-1:0]  run_cnt;
  logic              mode;

  wstream_line_track #(
    .LINE_BYTES (LINE_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .st_valid  (st_valid),
    .st_line   (st_line),
    .st_mask   (st_mask),
    .ld_valid  (ld_valid),
    .ld_line   (ld_line),
    .trk_valid (trk_valid),
    .trk_line  (trk_line),
    .evt       (evt),
    .done_line (done_line)
  );

  wstream_run_count #(
    .ADDR_W (ADDR_W),
    .THRESH (THRESH)
  ) u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt       (evt),
    .done_line (done_line),
    .run_cnt   (run_cnt),
    .mode      (mode)
  );

  assign stream_mode = mode;
  assign dec_valid   = st_valid && st_miss;
  assign dec_nofill  = dec_valid && mode;

endmodule

// File: rtl/wstream_detect_chk.sv
module wstream_detect_chk #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned THRESH = 4,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_line,
  input logic              trk_valid,
  input logic [ADDR_W-1:0] trk_line,
  input logic [CNT_W-1:0]  run_cnt,
  input logic              stream_mode
);

  // R5: the run count never passes the threshold.
  p_cnt_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(THRESH));

  // R5: the mode can only rise after a store event.
  p_enter_on_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_mode) |-> $past(st_valid));

  // R6/R7: the mode can only fall after some traffic.
  p_exit_on_traffic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stream_mode) |-> $past(st_valid || ld_valid));

  // R3: with no traffic, the mode holds.
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !ld_valid) |=> $stable(stream_mode));

  // R6: a load to the tracked line with no store leaves the mode low.
  p_load_hit_exits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && trk_valid && (ld_line == trk_line) && !st_valid)
      |=> (!stream_mode && run_cnt == '0));

endmodule

bind wstream_detect wstream_detect_chk #(
  .ADDR_W (ADDR_W),
  .THRESH (THRESH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_valid    (st_valid),
  .ld_valid    (ld_valid),
  .ld_line     (ld_line),
  .trk_valid   (trk_valid),
  .trk_line    (trk_line),
  .run_cnt     (run_cnt),
  .stream_mode (stream_mode)
);

// File: tb/tb_wstream_detect.sv
module tb_wstream_detect;
  localparam int unsigned LB = 64;
  localparam int unsigned AW = 16;
  localparam int unsigned NV = 27;

  logic          clk;
  logic          rst_n;
  logic          st_valid, st_miss, ld_valid;
  logic [AW-1:0] st_line, ld_line;
  logic [LB-1:0] st_mask;
  logic          stream_mode, dec_valid, dec_nofill;

  int checks = 0;
  int failures = 0;
  bit done_run = 0;

  wstream_detect #(.LINE_BYTES(LB), .ADDR_W(AW), .THRESH(4)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_miss(st_miss),
    .st_line(st_line), .st_mask(st_mask), .ld_valid(ld_valid), .ld_line(ld_line),
    .stream_mode(stream_mode), .dec_valid(dec_valid), .dec_nofill(dec_nofill)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: st_v, miss, line[8], mask code[2], ld_v, ld_line[8], exp nofill, exp mode after.
  // Mask codes: 0 none, 1 all bytes, 2 bytes 0..31, 3 bytes 32..63.
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,1'b1,8'd10,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd11,2'd2,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b0,8'd11,2'd3,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd12,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd13,2'd1,1'b0,8'd0, 1'b0,1'b1},
    {1'b1,1'b1,8'd14,2'd1,1'b0,8'd0, 1'b1,1'b1},
    {1'b1,1'b1,8'd15,2'd1,1'b0,8'd0, 1'b1,1'b1},
    {1'b1,1'b1,8'd16,2'd2,1'b0,8'd0, 1'b1,1'b1},
    {1'b0,1'b0,8'd0, 2'd0,1'b1,8'd16,1'b0,1'b0},
    {1'b1,1'b1,8'd17,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd18,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd19,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd20,2'd1,1'b0,8'd0, 1'b0,1'b1},
    {1'b1,1'b1,8'd22,2'd1,1'b0,8'd0, 1'b1,1'b0},
    {1'b1,1'b1,8'd23,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd24,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd25,2'd1,1'b0,8'd0, 1'b0,1'b1},
    {1'b1,1'b1,8'd26,2'd2,1'b0,8'd0, 1'b1,1'b1},
    {1'b1,1'b1,8'd30,2'd1,1'b0,8'd0, 1'b1,1'b0},
    {1'b0,1'b0,8'd0, 2'd0,1'b1,8'd31,1'b0,1'b0},
    {1'b1,1'b1,8'd31,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b0,1'b0,8'd0, 2'd0,1'b1,8'd31,1'b0,1'b0},
    {1'b1,1'b1,8'd32,2'd1,1'b0,8'd0, 1'b0,1'b0},
    {1'b1,1'b1,8'd33,2'd1,1'b0,8'd0, 1'b0,1'b1},
    {1'b1,1'b1,8'd34,2'd2,1'b1,8'd34,1'b1,1'b1},
    {1'b1,1'b1,8'd34,2'd3,1'b1,8'd34,1'b1,1'b0},
    {1'b1,1'b1,8'd34,2'd2,1'b0,8'd0, 1'b0,1'b0}
  };

  function automatic logic [LB-1:0] mask_of(input logic [1:0] code);
    case (code)
      2'd1:    return '1;
      2'd2:    return {{(LB/2){1'b0}}, {(LB/2){1'b1}}};
      2'd3:    return {{(LB/2){1'b1}}, {(LB/2){1'b0}}};
      default: return '0;
    endcase
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    st_valid = 1'b0; st_miss = 1'b0; st_line = '0; st_mask = '0;
    ld_valid = 1'b0; ld_line = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic full_store(input int line);
    st_valid = 1'b1; st_miss = 1'b1; st_line = AW'(line); st_mask = '1;
    ld_valid = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    do_reset();
    // R1: reset state
    #1;
    check(stream_mode, 0, "R1 mode after reset");
    check(dec_valid, 0, "R1 no decision when idle");

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      @(negedge clk);
      st_valid = v[22]; st_miss = v[21]; st_line = AW'(v[20:13]);
      st_mask = mask_of(v[12:11]); ld_valid = v[10]; ld_line = AW'(v[9:2]);
      #1;
      // R2: decision given with the mode held before this store
      check(dec_valid, v[22] & v[21], $sformatf("R2 dec_valid vec %0d", i));
      if (v[22] & v[21])
        check(dec_nofill, v[1], $sformatf("R2 dec_nofill vec %0d", i));
      @(posedge clk); #1;
      // R3..R8: mode after the edge (see table comments in brief)
      check(stream_mode, v[0], $sformatf("R3-8 table mode vec %0d (R4 R5 R6 R7 R8)", i));
    end

    // R5: a store hit in streaming mode gives no decision
    @(negedge clk); idle_inputs(); do_reset();
    for (int k = 40; k < 44; k++) full_store(k);
    check(stream_mode, 1, "R5 mode after four consecutive lines");
    st_valid = 1'b1; st_miss = 1'b0; st_line = AW'(44); st_mask = '1; #1;
    check(dec_valid, 0, "R2 store hit gives no decision");
    @(posedge clk); #1;
    check(stream_mode, 1, "R5 saturated run keeps mode");

    // R1: reset in the middle of a run clears the mode
    @(negedge clk); idle_inputs();
    rst_n = 1'b0; #1;
    check(stream_mode, 0, "R1 asynchronous reset clears mode");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    full_store(45);
    check(stream_mode, 0, "R1 run restarts after reset");

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done_run) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule